// File: doc/BRIEF.md
# Circular Pass Window Finder

This block locates one contiguous run of passing delay taps in a pass/fail vector that covers a full delay period. Each bit of the vector holds the outcome of one tap. Tap 0 follows tap 63, so a window may wrap across the end of the vector. In that case its endpoints are reported in an unrolled coordinate that can exceed 63.

A caller supplies the vector, a low marker and a high marker, and pulses `start`. The search begins at the high marker. When that tap passes, the block walks right until it reaches the first failing tap. When that tap fails, it walks left until it reaches the first passing tap. From the right end found this way, it walks left again to find the failing tap that bounds the window. Each walk visits one tap per clock.

The result gives both window endpoints and two signed edge distances: the right end minus the high marker, and the low marker minus the left end. The result also carries an error code. A one-cycle `done` pulse marks the result, and the outputs hold until the next accepted start.

Top module: `circ_pass_window`

## Requirements
- R1: After reset `done`, `err`, `err_code`, `win_lo`, `win_hi`, `diff_hi` and `diff_lo` are all zero.
- R2: If `hi_mark` is less than `lo_mark`, the run ends with `err`=1 and `err_code`=1. This check takes priority over all other checks.
- R3: If every bit of `fail_vec` is 1 (bit i = 1 means tap i fails), the run ends with `err_code`=2.
- R4: If every bit of `fail_vec` is 0, the run ends with `err`=1, `err_code`=3, `win_lo`=0 and `win_hi`=63. The two distances are still computed from that full window.
- R5: If tap `hi_mark` mod 64 passes, the block scans upward through positions taken mod 64. `win_hi` is the position just below the first failing tap, and it may exceed 63.
- R6: The upward scan stops with `err_code`=4 if it passes its limit without finding a fail. The limit is 127 when `hi_mark` > 63, and `hi_mark`+63 otherwise.
- R7: If tap `hi_mark` mod 64 fails, the block scans downward for the first passing position, which becomes `win_hi`. If no pass is found by the limit, the run ends with `err_code`=5. The limit is `hi_mark`-63 when `hi_mark` > 63, and 0 otherwise.
- R8: From `win_hi` the block scans downward for a failing tap, and `win_lo` is one above it. If no fail is found by the limit, the run ends with `err_code`=6. The limit is `win_hi`-63 when `win_hi` > 63, and 0 otherwise.
- R9: On success (`err_code`=0), `diff_hi` = `win_hi` - `hi_mark` and `diff_lo` = `lo_mark` - `win_lo`, both 8-bit two's complement. For error codes 1, 2, 4, 5 and 6, both windows and both distances are zero.
- R10: `done` is high for exactly one cycle per run. All result outputs hold their values until the next run finishes.
- R11: A `start` that arrives while a run is in progress is ignored and does not change that run's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a run when the block is idle |
| fail_vec | input | 64 | Per-tap outcome, 1 = fail |
| lo_mark | input | 6 | Low marker, also the low limit |
| hi_mark | input | 7 | High marker where the search starts, also the high limit |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Run ended in error |
| err_code | output | 3 | 0 ok, 1 bad markers, 2 no pass, 3 no fail, 4/5/6 scan limit exceeded |
| win_lo | output | 7 | Window left end (unrolled) |
| win_hi | output | 7 | Window right end (unrolled) |
| diff_hi | output | 8 | win_hi minus hi_mark, signed |
| diff_lo | output | 8 | lo_mark minus win_lo, signed |

## Verification
The hardest outcomes to reach are the three scan-limit errors. Neither an all-pass nor an all-fail vector can reach them; each needs a mixed vector in which the scan runs out of range before it finds the tap it is looking for. The stimulus table covers these cases:
- a high marker of 127 that sits on a pass, so the upward range is a single position;
- a marker on a fail below a pass window that lies entirely above it;
- a pass window that starts at tap 0, so the left-edge scan reaches position 0 while still in passes.

Wrapped windows are reached from both sides, with the marker below and above 63, and the resulting endpoints above 63 are checked.

// File: rtl/cpw_pkg.sv
package cpw_pkg;

  typedef enum logic [2:0] {
    CPW_OK        = 3'd0,
    CPW_BAD_MARK  = 3'd1,
    CPW_NO_PASS   = 3'd2,
    CPW_NO_FAIL   = 3'd3,
    CPW_RIGHT_EXH = 3'd4,
    CPW_LEFT_EXH  = 3'd5,
    CPW_EDGE_EXH  = 3'd6
  } cpw_err_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SCREEN,
    ST_RIGHT,
    ST_LEFT_PASS,
    ST_LEFT_EDGE
  } cpw_state_e;

  // Last position the upward walk may visit.
  function automatic int right_lim(input int pos, input int taps);
    return (pos > taps - 1) ? (2 * taps - 1) : (pos + taps - 1);
  endfunction

  // Lowest position a downward walk may visit.
  function automatic int left_lim(input int pos, input int taps);
    return (pos > taps - 1) ? (pos - taps + 1) : 0;
  endfunction

  // Signed edge distance.
  function automatic int edge_gap(input int a, input int b);
    return a - b;
  endfunction

endpackage

// File: rtl/cpw_tap_sel.sv
module cpw_tap_sel #(
  parameter int TAPS = 64,
  localparam int W  = $clog2(TAPS),
  localparam int PW = W + 1
) (
  input  logic [TAPS-1:0] vec,
  input  logic [PW-1:0]   pos,
  output logic            is_fail
);
  logic [PW-1:0] wrapped;

  always_comb begin
    wrapped = pos % PW'(TAPS);
    is_fail = vec[wrapped[W-1:0]];
  end
endmodule

// File: rtl/cpw_screen.sv
module cpw_screen #(
  parameter int TAPS = 64
) (
  input  logic [TAPS-1:0] vec,
  output logic            all_fail,
  output logic            all_pass
);
  assign all_fail = &vec;
  assign all_pass = ~|vec;
endmodule

// File: rtl/cpw_ctrl.sv
module cpw_ctrl
  import cpw_pkg::*;
#(
  parameter int TAPS = 64,
  localparam int W  = $clog2(TAPS),
  localparam int PW = W + 1,
  localparam int DW = W + 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [TAPS-1:0] fail_vec,
  input  logic [W-1:0]    lo_mark,
  input  logic [PW-1:0]   hi_mark,
  input  logic            tap_fail,
  input  logic            all_fail,
  input  logic            all_pass,
  output logic [TAPS-1:0] vec_q,
  output logic [PW-1:0]   cur_q,
  output logic            busy,
  output logic            done,
  output logic            err,
  output logic [2:0]      err_code,
  output logic [PW-1:0]   win_lo,
  output logic [PW-1:0]   win_hi,
  output logic [DW-1:0]   diff_hi,
  output logic [DW-1:0]   diff_lo
);
  cpw_state_e    state_q, state_d;
  logic [PW-1:0] cur_d, lim_q, lim_d, whi_q, whi_d;
  logic [W-1:0]  lo_q;
  logic [PW-1:0] hi_q;
  logic          fin;
  cpw_err_e      fcode;
  logic [PW-1:0] flo, fhi;
  logic [DW-1:0] fdhi, fdlo;
  logic [PW-1:0] cur_dn;

  assign busy   = (state_q != ST_IDLE);
  assign cur_dn = cur_q - PW'(1);

  always_comb begin
    state_d = state_q;
    cur_d   = cur_q;
    lim_d   = lim_q;
    whi_d   = whi_q;
    fin     = 1'b0;
    fcode   = CPW_OK;
    flo     = '0;
    fhi     = '0;
    fdhi    = '0;
    fdlo    = '0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_SCREEN;
          cur_d   = hi_mark;
        end
      end
      ST_SCREEN: begin
        if (hi_q < {1'b0, lo_q}) begin
          fin = 1'b1; fcode = CPW_BAD_MARK;
        end else if (all_fail) begin
          fin = 1'b1; fcode = CPW_NO_PASS;
        end else if (all_pass) begin
          fin   = 1'b1; fcode = CPW_NO_FAIL;
          flo   = '0;
          fhi   = PW'(TAPS - 1);
          fdhi  = DW'(edge_gap(TAPS - 1, int'(hi_q)));
          fdlo  = DW'(edge_gap(int'(lo_q), 0));
        end else if (!tap_fail) begin
          state_d = ST_RIGHT;
          lim_d   = PW'(right_lim(int'(hi_q), TAPS));
        end else begin
          state_d = ST_LEFT_PASS;
          lim_d   = PW'(left_lim(int'(hi_q), TAPS));
        end
      end
      ST_RIGHT: begin
        if (!tap_fail) begin
          if (cur_q == lim_q) begin
            fin = 1'b1; fcode = CPW_RIGHT_EXH;
          end else begin
            cur_d = cur_q + PW'(1);
          end
        end else begin
          whi_d   = cur_dn;
          cur_d   = cur_dn;
          lim_d   = PW'(left_lim(int'(cur_dn), TAPS));
          state_d = ST_LEFT_EDGE;
        end
      end
      ST_LEFT_PASS: begin
        if (tap_fail) begin
          if (cur_q == lim_q) begin
            fin = 1'b1; fcode = CPW_LEFT_EXH;
          end else begin
            cur_d = cur_dn;
          end
        end else begin
          whi_d   = cur_q;
          lim_d   = PW'(left_lim(int'(cur_q), TAPS));
          state_d = ST_LEFT_EDGE;
        end
      end
      ST_LEFT_EDGE: begin
        if (!tap_fail) begin
          if (cur_q == lim_q) begin
            fin = 1'b1; fcode = CPW_EDGE_EXH;
          end else begin
            cur_d = cur_dn;
          end
        end else begin
          fin  = 1'b1;
          fcode = CPW_OK;
          flo  = cur_q + PW'(1);
          fhi  = whi_q;
          fdhi = DW'(edge_gap(int'(whi_q), int'(hi_q)));
          fdlo = DW'(edge_gap(int'(lo_q), int'(cur_q) + 1));
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (fin) state_d = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      cur_q    <= '0;
      lim_q    <= '0;
      whi_q    <= '0;
      vec_q    <= '0;
      lo_q     <= '0;
      hi_q     <= '0;
      done     <= 1'b0;
      err      <= 1'b0;
      err_code <= '0;
      win_lo   <= '0;
      win_hi   <= '0;
      diff_hi  <= '0;
      diff_lo  <= '0;
    end else begin
      state_q <= state_d;
      cur_q   <= cur_d;
      lim_q   <= lim_d;
      whi_q   <= whi_d;
      done    <= fin;
      if (state_q == ST_IDLE && start) begin
        vec_q <= fail_vec;
        lo_q  <= lo_mark;
        hi_q  <= hi_mark;
      end
      if (fin) begin
        err      <= (fcode != CPW_OK);
        err_code <= fcode;
        win_lo   <= flo;
        win_hi   <= fhi;
        diff_hi  <= fdhi;
        diff_lo  <= fdlo;
      end
    end
  end
endmodule

// File: rtl/circ_pass_window.sv
module circ_pass_window #(
  parameter int TAPS = 64,
  localparam int W  = $clog2(TAPS),
  localparam int PW = W + 1,
  localparam int DW = W + 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [TAPS-1:0] fail_vec,
  input  logic [W-1:0]    lo_mark,
  input  logic [PW-1:0]   hi_mark,
  output logic            done,
  output logic            err,
  output logic [2:0]      err_code,
  output logic [PW-1:0]   win_lo,
  output logic [PW-1:0]   win_hi,
  output logic [DW-1:0]   diff_hi,
  output logic [DW-1:0]   diff_lo
);
  logic [TAPS-1:0] vec_q;
  logic [PW-1:0]   cur_q;
  logic            tap_fail, all_fail, all_pass, busy;

  cpw_tap_sel #(.TAPS(TAPS)) u_tap (
    .vec(vec_q), .pos(cur_q), .is_fail(tap_fail)
  );

  cpw_screen #(.TAPS(TAPS)) u_screen (
    .vec(vec_q), .all_fail(all_fail), .all_pass(all_pass)
  );

  cpw_ctrl #(.TAPS(TAPS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .fail_vec(fail_vec),
    .lo_mark(lo_mark), .hi_mark(hi_mark), .tap_fail(tap_fail),
    .all_fail(all_fail), .all_pass(all_pass), .vec_q(vec_q),
    .cur_q(cur_q), .busy(busy), .done(done), .err(err),
    .err_code(err_code), .win_lo(win_lo), .win_hi(win_hi),
    .diff_hi(diff_hi), .diff_lo(diff_lo)
  );
endmodule

// File: rtl/cpw_checker.sv
module cpw_checker #(
  parameter int TAPS = 64,
  localparam int W  = $clog2(TAPS),
  localparam int PW = W + 1,
  localparam int DW = W + 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            busy,
  input logic [TAPS-1:0] vec_q,
  input logic            done,
  input logic            err,
  input logic [2:0]      err_code,
  input logic [PW-1:0]   win_lo,
  input logic [PW-1:0]   win_hi,
  input logic [DW-1:0]   diff_hi,
  input logic [DW-1:0]   diff_lo
);
  logic [W-1:0] hi_tap, hi_next, lo_tap, lo_prev;

  always_comb begin
    hi_tap  = W'(win_hi % PW'(TAPS));
    hi_next = hi_tap + W'(1);
    lo_tap  = W'(win_lo % PW'(TAPS));
    lo_prev = lo_tap - W'(1);
  end

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(win_lo) && $stable(win_hi) && $stable(err_code)
               && $stable(diff_hi) && $stable(diff_lo)));

  // R5 and R8: a good window is bounded by fails and ends on passes.
  assert_window_edges_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> (!vec_q[hi_tap] && vec_q[hi_next]
                        && !vec_q[lo_tap] && vec_q[lo_prev]));

  assert_full_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err_code == 3'd3) |-> (win_lo == '0 && win_hi == PW'(TAPS - 1)));

  assert_err_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err && err_code != 3'd3) |->
      (win_lo == '0 && win_hi == '0 && diff_hi == '0 && diff_lo == '0));

  assert_busy_ignore_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(vec_q));
endmodule

bind circ_pass_window cpw_checker #(.TAPS(TAPS)) u_cpw_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .vec_q(vec_q),
  .done(done), .err(err), .err_code(err_code), .win_lo(win_lo),
  .win_hi(win_hi), .diff_hi(diff_hi), .diff_lo(diff_lo)
);

// File: tb/test_circ_pass_window.sv
module test_circ_pass_window;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [63:0] fail_vec = '0;
  logic [5:0]  lo_mark = '0;
  logic [6:0]  hi_mark = '0;
  logic        done, err;
  logic [2:0]  err_code;
  logic [6:0]  win_lo, win_hi;
  logic [7:0]  diff_hi, diff_lo;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  circ_pass_window i_circ_pass_window (
    .clk(clk), .rst_n(rst_n), .start(start), .fail_vec(fail_vec),
    .lo_mark(lo_mark), .hi_mark(hi_mark), .done(done), .err(err),
    .err_code(err_code), .win_lo(win_lo), .win_hi(win_hi),
    .diff_hi(diff_hi), .diff_lo(diff_lo)
  );

  typedef struct packed {
    logic [63:0]        vec;
    logic [5:0]         lo;
    logic [6:0]         hi;
    logic [2:0]         code;
    logic [6:0]         wlo;
    logic [6:0]         whi;
    logic signed [7:0]  dhi;
    logic signed [7:0]  dlo;
  } case_t;

  localparam int NCASE = 14;
  localparam case_t CASES [NCASE] = '{
    {64'hFFFFFFFFC00003FF, 6'd12, 7'd25,  3'd0, 7'd10, 7'd29,  8'sd4,   8'sd2},   // R5 plain
    {64'hFFFFFFFFC00003FF, 6'd5,  7'd35,  3'd0, 7'd10, 7'd29, -8'sd6,  -8'sd5},   // R7 left to pass
    {64'h0FFFFFFFFFFFFFC0, 6'd58, 7'd62,  3'd0, 7'd60, 7'd69,  8'sd7,  -8'sd2},   // R5 wraps up
    {64'h0FFFFFFFFFFFFFC0, 6'd61, 7'd66,  3'd0, 7'd60, 7'd69,  8'sd3,   8'sd1},   // R6 marker above 63
    {64'h0FFFFFFFFFFFFFC0, 6'd0,  7'd3,   3'd6, 7'd0,  7'd0,   8'sd0,   8'sd0},   // R8 edge exhausted
    {64'h0FFFFFFFFFFFFFC0, 6'd0,  7'd127, 3'd4, 7'd0,  7'd0,   8'sd0,   8'sd0},   // R6 right exhausted
    {64'hFFFFC0FFFFFFFFFF, 6'd0,  7'd20,  3'd5, 7'd0,  7'd0,   8'sd0,   8'sd0},   // R7 pass exhausted
    {64'hFFFFC0FFFFFFFFFF, 6'd10, 7'd50,  3'd0, 7'd40, 7'd45, -8'sd5,  -8'sd30},  // R7
    {64'hFFFFC0FFFFFFFFFF, 6'd30, 7'd100, 3'd0, 7'd40, 7'd45, -8'sd55, -8'sd10},  // R7 wrapped down
    {64'hFFFFFFFFC00003FF, 6'd6,  7'd5,   3'd1, 7'd0,  7'd0,   8'sd0,   8'sd0},   // R2
    {64'hFFFFFFFFFFFFFFFF, 6'd0,  7'd0,   3'd2, 7'd0,  7'd0,   8'sd0,   8'sd0},   // R3
    {64'h0000000000000000, 6'd10, 7'd20,  3'd3, 7'd0,  7'd63,  8'sd43,  8'sd10},  // R4
    {64'hFFFFFFFFFFFFFFFF, 6'd9,  7'd3,   3'd1, 7'd0,  7'd0,   8'sd0,   8'sd0},   // R2 priority over R3
    {64'hFFFFFFFFFFFFFFFE, 6'd0,  7'd64,  3'd0, 7'd64, 7'd64,  8'sd0,  -8'sd64}   // R5 single tap, R9
  };

  function automatic string req_of(input logic [2:0] code);
    case (code)
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R6";
      3'd5: return "R7";
      3'd6: return "R8";
      default: return "R5";
    endcase
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic pulse_start(input logic [63:0] v, input logic [5:0] lo, input logic [6:0] hi);
    @(negedge clk);
    fail_vec = v; lo_mark = lo; hi_mark = hi; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output bit ok);
    ok = 1'b0;
    for (int n = 0; n < 500; n++) begin
      if (done) begin ok = 1'b1; break; end
      @(negedge clk);
    end
    if (!ok) chk("R10", "watchdog done", 0, 1);
  endtask

  initial begin
    #(8 * 150000);
    failures++;
    checks++;
    $display("FAIL R10 global watchdog: actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    bit ok;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "done", done, 0);
    chk("R1", "err", err, 0);
    chk("R1", "err_code", err_code, 0);
    chk("R1", "win", {win_lo, win_hi}, 0);
    chk("R1", "diffs", {diff_hi, diff_lo}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NCASE; i++) begin
      case_t c = CASES[i];
      string rq = req_of(c.code);
      pulse_start(c.vec, c.lo, c.hi);
      wait_done(ok);
      if (ok) begin
        chk(rq, "err_code", err_code, c.code);
        chk(rq, "err", err, (c.code != 3'd0));
        chk(rq, "win_lo", win_lo, c.wlo);
        chk(rq, "win_hi", win_hi, c.whi);
        chk("R9", "diff_hi", $signed(diff_hi), c.dhi);
        chk("R9", "diff_lo", $signed(diff_lo), c.dlo);
      end
      @(negedge clk);
      chk("R10", "done width", done, 0);
    end

    // R11: second start during a run is ignored
    pulse_start(64'hFFFFFFFFC00003FF, 6'd12, 7'd25);
    @(negedge clk);
    fail_vec = '1; lo_mark = 6'd0; hi_mark = 7'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(ok);
    if (ok) begin
      chk("R11", "err_code", err_code, 0);
      chk("R11", "win_lo", win_lo, 10);
      chk("R11", "win_hi", win_hi, 29);
    end

    // R10: results hold while idle
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk("R10", "done low", done, 0);
    end
    chk("R10", "held win", {win_lo, win_hi}, {7'd10, 7'd29});
    chk("R10", "held diff", {diff_hi, diff_lo}, {8'd4, 8'd2});

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule